// File: doc/BRIEF.md
# Gear-Ratio Digital Phase Aligner

This block keeps a fast bus clock in step with a slower system clock when the two run at a fixed rational ratio. Everything runs on one fine timebase, `clk`, whose period is the step size of an ideal multiphase delay line. The bus clock spans `BUS_TICKS` timebase cycles, and the sync clock is the bus clock divided by 4. The sync clock is divided again by N. Rising edges of the system clock arrive as one-cycle strobes on `sys_edge`, and every M-th strobe gives a divided system edge. When the ratio is chosen so that both divided clocks share one frequency, an edge-order detector compares them once per divided period. A saturating tap counter then moves the selected bus clock phase by one delay step toward alignment.

The loop has two state machines. The detector rests in IDLE. When only a divided system edge arrives, IDLE goes to SYS_LEAD. When only a divided sync edge arrives, IDLE goes to SYNC_LEAD. When both arrive in one cycle, the detector decides "tie" and stays in IDLE. SYS_LEAD ends on the next sync edge with a "down" decision. SYNC_LEAD ends on the next system edge with an "up" decision. A ratio load or a paused loop sends the detector back to IDLE.

The lock tracker starts in ACQUIRE. It goes from ACQUIRE to LOCKED after 8 qualifying decisions in a row. It goes from ACQUIRE to TIMEOUT when the cycle budget runs out. LOCKED and TIMEOUT are held until the next ratio load, which returns the tracker to ACQUIRE. Stopping the output clock or selecting bypass freezes the loop, and the tap it had reached is kept. For taps to be reachable, `TAPS` must not exceed `4*BUS_TICKS`.

Top module: `gear_phase_aligner`

## Requirements
- R1: The bus phase count runs from 0 to 4·N·BUS_TICKS−1 and wraps, so with the defaults the sync divided edge repeats every 16·N cycles. That edge occurs in the cycle in which the count equals the tap. `sys_div_pulse` marks every M-th `sys_edge`. `sync_div_pulse` and `sys_div_pulse` are one-cycle pulses, registered one cycle after their edge.
- R2: A ratio value of 0 on `ratio_m` or `ratio_n` is taken as 1.
- R3: A `ratio_load` pulse takes in the new M and N and restarts both dividers. The bus phase count is 0 in the cycle after the load, and the system strobe count restarts. The load also clears `locked` and `timeout`, while the tap keeps its value.
- R4: If the divided sync edge comes first, the tap rises by one. If the divided system edge comes first, the tap falls by one. If both come in the same cycle, the tap holds. The tap moves by at most one step per decision.
- R5: The tap saturates at 0 and at TAPS−1 and never wraps.
- R6: A decision qualifies when it is a tie, or when its direction differs from the previous decision. `locked` rises after 8 qualifying decisions in a row. When locked, the tap is the one at which the two divided edges coincide.
- R7: `timeout` rises exactly LOCK_LIMIT active cycles after a ratio load if lock has not been reached by then.
- R8: While `clk_stop` is high, `sync_div_pulse` stays low, and the tap and lock state are frozen regardless of `sys_edge`. The same tap is in force after the clock restarts.
- R9: While `bypass` is high, `phase_sel` reads 0, `locked` reads 0, and the loop is frozen. When bypass is released, the earlier tap and lock state return.
- R10: After reset, `phase_sel` equals TAP_INIT (8 by default), and `locked` and `timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine timebase; one period is one delay-line step |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_m | input | RATIO_W | System-side divide ratio M |
| ratio_n | input | RATIO_W | Sync-side divide ratio N |
| ratio_load | input | 1 | One-cycle pulse that applies the new M and N |
| sys_edge | input | 1 | Strobe for each system clock rising edge |
| clk_stop | input | 1 | High while the output clock is stopped |
| bypass | input | 1 | High to route the multiplied clock without phase alignment |
| phase_sel | output | TAP_W | Selected delay-line tap |
| locked | output | 1 | Loop dithering about zero error |
| timeout | output | 1 | Lock not reached within the cycle budget |
| sync_div_pulse | output | 1 | Divided sync clock edge pulse |
| sys_div_pulse | output | 1 | Divided system clock edge pulse |

## Verification
The bench sets up exact coincidence of the divided edges. A design that mishandles the same-cycle tie would step past the target and dither without ever locking. It also forces a target beyond the top tap. A counter that wraps instead of saturating would jump to tap 0 and lock on the wrong phase. The bench checks that the timeout appears on exactly the cycle given by the budget, which catches an off-by-one in the budget counter. It also moves the system phase while the clock is stopped or bypassed. A loop that is not truly frozen would move the tap and come back from the stop misaligned. Finally, it loads ratio 0, which a naive divider would turn into an all-ones count.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {DIR_NONE, DIR_UP, DIR_DN} dir_e;
    typedef enum logic [1:0] {DET_IDLE, DET_SYS_LEAD, DET_SYNC_LEAD} det_state_e;
    typedef enum logic [1:0] {LK_ACQ, LK_LOCKED, LK_TIMEOUT} lock_state_e;
endpackage

// File: rtl/pa_ratio_div.sv
module pa_ratio_div #(
    parameter int RATIO_W   = 4,
    parameter int BUS_TICKS = 4,
    parameter int TAP_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_m,
    input  logic [RATIO_W-1:0] ratio_n,
    input  logic               ratio_load,
    input  logic               sys_edge,
    input  logic [TAP_W-1:0]   tap,
    output logic               sync_ev,
    output logic               sys_ev
);
    localparam int MAX_PERIOD = 4 * ((1 << RATIO_W) - 1) * BUS_TICKS;
    localparam int PH_W       = $clog2(MAX_PERIOD + 1);
    localparam logic [PH_W-1:0] SYNC_TICKS = PH_W'(4 * BUS_TICKS);

    logic [RATIO_W-1:0] m_q, n_q;
    logic [RATIO_W-1:0] sys_cnt;
    logic [PH_W-1:0]    bus_ph;
    logic [PH_W-1:0]    period_last;

    assign period_last = PH_W'(n_q) * SYNC_TICKS - PH_W'(1);

    // ratio registers; zero is taken as one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= RATIO_W'(1);
            n_q <= RATIO_W'(1);
        end else if (ratio_load) begin
            m_q <= (ratio_m == '0) ? RATIO_W'(1) : ratio_m;
            n_q <= (ratio_n == '0) ? RATIO_W'(1) : ratio_n;
        end
    end

    // bus phase count: bus/4 then /N
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    bus_ph <= '0;
        else if (ratio_load)           bus_ph <= '0;
        else if (bus_ph == period_last) bus_ph <= '0;
        else                           bus_ph <= bus_ph + 1'b1;
    end

    // system strobe count: divide by M
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sys_cnt <= '0;
        else if (ratio_load) sys_cnt <= '0;
        else if (sys_edge)   sys_cnt <= (sys_cnt == m_q - RATIO_W'(1)) ? '0 : sys_cnt + 1'b1;
    end

    assign sync_ev = !ratio_load && (bus_ph == PH_W'(tap));
    assign sys_ev  = !ratio_load && sys_edge && (sys_cnt == m_q - RATIO_W'(1));

    assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ph <= period_last);
endmodule

// File: rtl/pa_edge_order_det.sv
module pa_edge_order_det
    import pa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sync_ev,
    input  logic sys_ev,
    output logic dec_up,
    output logic dec_dn,
    output logic dec_tie
);
    det_state_e st_q, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DET_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        if (clear) begin
            st_nxt = DET_IDLE;
        end else begin
            unique case (st_q)
                DET_IDLE: begin
                    if (sync_ev && !sys_ev)      st_nxt = DET_SYNC_LEAD;
                    else if (sys_ev && !sync_ev) st_nxt = DET_SYS_LEAD;
                end
                DET_SYNC_LEAD: begin
                    if (sys_ev) st_nxt = sync_ev ? DET_SYNC_LEAD : DET_IDLE;
                end
                DET_SYS_LEAD: begin
                    if (sync_ev) st_nxt = sys_ev ? DET_SYS_LEAD : DET_IDLE;
                end
                default: st_nxt = DET_IDLE;
            endcase
        end
    end

    always_comb begin
        dec_up  = 1'b0;
        dec_dn  = 1'b0;
        dec_tie = 1'b0;
        if (!clear) begin
            unique case (st_q)
                DET_IDLE:      dec_tie = sync_ev && sys_ev;
                DET_SYNC_LEAD: dec_up  = sys_ev;
                DET_SYS_LEAD:  dec_dn  = sync_ev;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pa_tap_lock.sv
module pa_tap_lock
    import pa_pkg::*;
#(
    parameter int TAPS       = 16,
    parameter int TAP_W      = 4,
    parameter int TAP_INIT   = 8,
    parameter int LOCK_RUN   = 8,
    parameter int LOCK_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ratio_load,
    input  logic             active,
    input  logic             dec_up,
    input  logic             dec_dn,
    input  logic             dec_tie,
    output logic [TAP_W-1:0] tap_q,
    output lock_state_e      lock_st
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int LIM_W = $clog2(LOCK_LIMIT);
    localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(TAPS - 1);
    localparam logic [TAP_W-1:0] TAP_RST = TAP_W'(TAP_INIT);

    lock_state_e      st_q, st_nxt;
    dir_e             prev_q;
    logic [RUN_W-1:0] run_q;
    logic [LIM_W-1:0] lim_q;
    logic             decided, qualify;

    assign decided = dec_up | dec_dn | dec_tie;
    assign qualify = dec_tie || (dec_up && prev_q != DIR_UP) || (dec_dn && prev_q != DIR_DN);

    // saturating tap counter, kept across loads, stops and bypass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           tap_q <= TAP_RST;
        else if (dec_up && tap_q != TAP_MAX)  tap_q <= tap_q + 1'b1;
        else if (dec_dn && tap_q != '0)       tap_q <= tap_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_ACQ;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        if (ratio_load) begin
            st_nxt = LK_ACQ;
        end else begin
            unique case (st_q)
                LK_ACQ: begin
                    if (decided && qualify && run_q == RUN_W'(LOCK_RUN - 1))
                        st_nxt = LK_LOCKED;
                    else if (active && lim_q == LIM_W'(LOCK_LIMIT - 1))
                        st_nxt = LK_TIMEOUT;
                end
                LK_LOCKED:  st_nxt = LK_LOCKED;
                LK_TIMEOUT: st_nxt = LK_TIMEOUT;
                default:    st_nxt = LK_ACQ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            lim_q  <= '0;
            prev_q <= DIR_NONE;
        end else if (ratio_load) begin
            run_q  <= '0;
            lim_q  <= '0;
            prev_q <= DIR_NONE;
        end else begin
            if (decided) begin
                prev_q <= dec_up ? DIR_UP : (dec_dn ? DIR_DN : DIR_NONE);
                if (st_q == LK_ACQ) run_q <= qualify ? run_q + 1'b1 : '0;
            end
            if (active && st_q == LK_ACQ && lim_q != LIM_W'(LOCK_LIMIT - 1))
                lim_q <= lim_q + 1'b1;
        end
    end

    assign lock_st = st_q;

    assert_tap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_q == $past(tap_q)) || (tap_q == $past(tap_q) + 1'b1) || (tap_q == $past(tap_q) - 1'b1));
    assert_tap_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q <= TAP_MAX);
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(tap_q));
    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_load |=> (st_q == LK_ACQ));
endmodule

// File: rtl/gear_phase_aligner.sv
module gear_phase_aligner
    import pa_pkg::*;
#(
    parameter int TAPS       = 16,
    parameter int BUS_TICKS  = 4,
    parameter int RATIO_W    = 4,
    parameter int LOCK_RUN   = 8,
    parameter int LOCK_LIMIT = 1024,
    parameter int TAP_INIT   = TAPS / 2,
    parameter int TAP_W      = $clog2(TAPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_m,
    input  logic [RATIO_W-1:0] ratio_n,
    input  logic               ratio_load,
    input  logic               sys_edge,
    input  logic               clk_stop,
    input  logic               bypass,
    output logic [TAP_W-1:0]   phase_sel,
    output logic               locked,
    output logic               timeout,
    output logic               sync_div_pulse,
    output logic               sys_div_pulse
);
    logic             sync_ev, sys_ev, active;
    logic             dec_up, dec_dn, dec_tie;
    logic [TAP_W-1:0] tap;
    lock_state_e      lock_st;

    assign active = !clk_stop && !bypass;

    pa_ratio_div #(.RATIO_W(RATIO_W), .BUS_TICKS(BUS_TICKS), .TAP_W(TAP_W)) div_i (
        .clk(clk), .rst_n(rst_n), .ratio_m(ratio_m), .ratio_n(ratio_n),
        .ratio_load(ratio_load), .sys_edge(sys_edge), .tap(tap),
        .sync_ev(sync_ev), .sys_ev(sys_ev));

    pa_edge_order_det det_i (
        .clk(clk), .rst_n(rst_n), .clear(ratio_load || !active),
        .sync_ev(sync_ev), .sys_ev(sys_ev),
        .dec_up(dec_up), .dec_dn(dec_dn), .dec_tie(dec_tie));

    pa_tap_lock #(.TAPS(TAPS), .TAP_W(TAP_W), .TAP_INIT(TAP_INIT),
                  .LOCK_RUN(LOCK_RUN), .LOCK_LIMIT(LOCK_LIMIT)) lock_i (
        .clk(clk), .rst_n(rst_n), .ratio_load(ratio_load), .active(active),
        .dec_up(dec_up), .dec_dn(dec_dn), .dec_tie(dec_tie),
        .tap_q(tap), .lock_st(lock_st));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_div_pulse <= 1'b0;
            sys_div_pulse  <= 1'b0;
        end else begin
            sync_div_pulse <= sync_ev && !clk_stop;
            sys_div_pulse  <= sys_ev;
        end
    end

    assign phase_sel = bypass ? '0 : tap;
    assign locked    = (lock_st == LK_LOCKED) && !bypass;
    assign timeout   = (lock_st == LK_TIMEOUT);

    assert_stop_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |=> !sync_div_pulse);
    assert_one_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_up, dec_dn, dec_tie}));
endmodule

// File: tb/gear_phase_aligner_tb_top.sv
`timescale 1ns/1ps
module gear_phase_aligner_tb_top;
    localparam int LIM = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ratio_m = 4'd1, ratio_n = 4'd1;
    logic       ratio_load = 1'b0, sys_edge = 1'b0, clk_stop = 1'b0, bypass = 1'b0;
    logic [3:0] phase_sel;
    logic       locked, timeout, sync_div_pulse, sys_div_pulse;

    int n_chk = 0, n_fail = 0;
    int gen_off = 0, gen_t = 16, jcnt = 0;
    bit gen_en = 0, do_load = 0;
    int sync_seen = 0, sys_seen = 0;

    always #2.5 clk = ~clk;

    gear_phase_aligner #(.LOCK_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .ratio_m(ratio_m), .ratio_n(ratio_n),
        .ratio_load(ratio_load), .sys_edge(sys_edge), .clk_stop(clk_stop),
        .bypass(bypass), .phase_sel(phase_sel), .locked(locked), .timeout(timeout),
        .sync_div_pulse(sync_div_pulse), .sys_div_pulse(sys_div_pulse));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one timebase cycle; samples outputs, then drives this cycle's inputs
    task automatic step();
        @(negedge clk);
        sync_seen += int'(sync_div_pulse);
        sys_seen  += int'(sys_div_pulse);
        if (do_load) begin
            ratio_load = 1'b1;
            sys_edge   = 1'b0;
            do_load    = 0;
            jcnt       = 0;
        end else begin
            ratio_load = 1'b0;
            sys_edge   = gen_en && (jcnt >= gen_off) && (((jcnt - gen_off) % gen_t) == 0);
            jcnt++;
        end
    endtask

    task automatic load_ratio(input int m, input int n, input int t, input int off);
        ratio_m = 4'(m); ratio_n = 4'(n);
        gen_t = t; gen_off = off; gen_en = 1; do_load = 1;
        step(); step();
        chk("R3 locked cleared by load", int'(locked), 0);
        chk("R3 timeout cleared by load", int'(timeout), 0);
    endtask

    task automatic wait_lock(input int exp_tap, input string req);
        for (int s = 0; s < LIM && !locked; s++) step();
        chk({req, " lock reached"}, int'(locked), 1);
        chk({req, " converged tap"}, int'(phase_sel), exp_tap);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) step();
        chk("R10 reset tap", int'(phase_sel), 8);
        rst_n = 1'b1;
        step();
        chk("R10 tap after reset", int'(phase_sel), 8);
        chk("R10 locked after reset", int'(locked), 0);
        chk("R10 timeout after reset", int'(timeout), 0);
    endtask

    task automatic t_acquire_up();
        load_ratio(2, 1, 8, 3);                 // edge at 3+8=11
        wait_lock(11, "R4 R6 upward");
        sync_seen = 0; sys_seen = 0;
        repeat (64) step();
        chk("R1 sync pulses N=1 per 64", sync_seen, 4);
        chk("R1 sys pulses M=2 per 64", sys_seen, 4);
    endtask

    task automatic t_acquire_m4();
        load_ratio(4, 1, 4, 1);                 // edge at 1+12=13
        wait_lock(13, "R6 M=4");
    endtask

    task automatic t_acquire_down();
        load_ratio(1, 1, 16, 6);                // edge at 6
        wait_lock(6, "R4 downward");
    endtask

    task automatic t_stop();
        int bad = 0;
        clk_stop = 1'b1;
        sync_seen = 0; sys_seen = 0;
        repeat (16) begin step(); bad += int'(phase_sel != 4'd6); end
        gen_off = 9;                            // move system phase while stopped
        repeat (32) begin step(); bad += int'(phase_sel != 4'd6); end
        gen_off = 6;
        repeat (16) begin step(); bad += int'(phase_sel != 4'd6); end
        chk("R8 tap frozen while stopped", bad, 0);
        chk("R8 no sync pulse while stopped", sync_seen, 0);
        chk("R8 sys pulses continue", int'(sys_seen > 0), 1);
        clk_stop = 1'b0;
        bad = 0; sync_seen = 0;
        repeat (64) begin step(); bad += int'(phase_sel != 4'd6); end
        chk("R8 tap retained after restart", bad, 0);
        chk("R8 lock kept after restart", int'(locked), 1);
        chk("R8 sync pulses resume", sync_seen, 4);
    endtask

    task automatic t_bypass();
        int bad = 0;
        bypass = 1'b1;
        gen_off = 9;
        repeat (48) begin step(); bad += int'(phase_sel != 4'd0) + int'(locked); end
        chk("R9 bypass forces tap 0 and no lock", bad, 0);
        gen_off = 6;
        repeat (16) step();
        bypass = 1'b0;
        step();
        chk("R9 tap restored after bypass", int'(phase_sel), 6);
        chk("R9 lock restored after bypass", int'(locked), 1);
    endtask

    task automatic t_zero_ratio();
        load_ratio(0, 0, 16, 6);
        wait_lock(6, "R2 zero ratio");
        sync_seen = 0; sys_seen = 0;
        repeat (64) step();
        chk("R2 N=0 acts as 1", sync_seen, 4);
        chk("R2 M=0 acts as 1", sys_seen, 4);
    endtask

    task automatic t_saturate_timeout();
        ratio_m = 4'd1; ratio_n = 4'd2;
        gen_t = 32; gen_off = 20; gen_en = 1; do_load = 1;
        step();
        for (int s = 1; s <= LIM + 1; s++) begin
            step();
            if (s == LIM)     chk("R7 no timeout before budget", int'(timeout), 0);
            if (s == LIM + 1) chk("R7 timeout at budget", int'(timeout), 1);
        end
        chk("R5 tap saturates at top", int'(phase_sel), 15);
        chk("R6 no lock when stuck at end", int'(locked), 0);
        do_load = 1;
        step(); step();
        chk("R3 load clears timeout", int'(timeout), 0);
        chk("R3 tap kept over load", int'(phase_sel), 15);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        t_reset();
        t_acquire_up();
        t_acquire_m4();
        t_acquire_down();
        t_stop();
        t_bypass();
        t_zero_ratio();
        t_saturate_timeout();
        summary();
    end
endmodule